// File: doc/BRIEF.md
# Register Window Trap Entry Sequencer

This block carries out the hardware part of entering a trap on a processor whose integer registers are organised as overlapping windows. When the core raises a trap request together with an 8-bit trap type, the sequencer captures the current window pointer, program counter, next program counter, status bits and trap base register. It then steps through a short fixed sequence. The window pointer moves down by one, wrapping around the window count. The old PC and nPC are stored into two local registers of the newly selected window. The status bits are rewritten, and the trap vector is built so that fetch can be redirected.

The register file is reached through one write port. The two saves therefore go out on back-to-back cycles, and a one-cycle completion pulse follows them. That pulse also clears the core's pending exception index. While a sequence is running, the block drops its ready output and ignores any further trap request.

Top module: `trap_entry`

## Requirements
- R1: After reset, `ready` is 1 and `done`, `excPendClr` and `rfWe` are 0.
- R2: The new window number on `newCwp` and `rfWin` is the captured `curCwp` minus one, modulo `NWIN`. Window 0 wraps to `NWIN-1`.
- R3: In the cycle after acceptance (`trapReq` high while `ready` is high), `rfWe` is 1. In that cycle `rfIdx` is 17 (local 1 of the window), `rfData` is the captured PC and `rfWin` is the new window.
- R4: In the next cycle `rfWe` is 1, `rfIdx` is 18 (local 2) and `rfData` is the captured nPC. In the cycle after that, `rfWe` is 0.
- R5: `newPs` takes the captured `curS` and `newS` is 1.
- R6: `newEt` is 0 after entry.
- R7: `newTbr` keeps `curTbr[31:12]`, puts the trap type in bits 11:4 and has bits 3:0 at zero.
- R8: `newPc` equals `newTbr` and `newNpc` equals `newTbr + 4`.
- R9: `done` and `excPendClr` are high for exactly one cycle, three cycles after acceptance and immediately after the second write.
- R10: `ready` is 0 from the cycle after acceptance through the `done` cycle. A `trapReq` in that span causes no extra write and does not change the results.
- R11: Changes on `curCwp`, `curPc`, `curNpc`, `curS`, `curTbr` or `trapType` after acceptance do not affect the writes or the results of the running entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | Trap entry request |
| trapType | input | 8 | Trap type code |
| ready | output | 1 | High when a request can be accepted |
| curPc | input | XLEN | Current program counter |
| curNpc | input | XLEN | Current next program counter |
| curCwp | input | log2(NWIN) | Current window pointer |
| curS | input | 1 | Current supervisor bit |
| curEt | input | 1 | Current trap-enable bit |
| curTbr | input | XLEN | Current trap base register |
| rfWe | output | 1 | Register file write enable |
| rfWin | output | log2(NWIN) | Window addressed by the write |
| rfIdx | output | 5 | Windowed register index of the write |
| rfData | output | XLEN | Write data |
| newCwp | output | log2(NWIN) | Window pointer after entry |
| newS | output | 1 | Supervisor bit after entry |
| newPs | output | 1 | Previous-supervisor bit after entry |
| newEt | output | 1 | Trap-enable bit after entry |
| newTbr | output | XLEN | Trap base register after entry |
| newPc | output | XLEN | Redirected fetch PC |
| newNpc | output | XLEN | Redirected next PC |
| done | output | 1 | One-cycle entry-complete pulse |
| excPendClr | output | 1 | One-cycle clear for the pending exception index |

## Verification
The bench tries every starting window, including the wrap from 0, with both supervisor values. Each of those is combined with trap types that are all-zero, all-one, alternating and high-bit-only, and with trap base values whose low twelve bits are full of ones. These patterns separate a correct modulo decrement from an off-by-one error, show whether the trap type sits in the right field, and show whether stale low bits of the base leak into the vector. Some entries also raise a second request and scramble every input while the sequence is running. This separates a design that captures its inputs at acceptance from one that reads them live, and a design that blocks requests while busy from one that restarts.

// File: rtl/trap_pkg.sv
package trap_pkg;

  // Sequencer phases; the write phases follow acceptance in this order
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_SAVE_PC  = 2'd1,
    ST_SAVE_NPC = 2'd2,
    ST_FINISH   = 2'd3
  } trapState_t;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic capture;   // latch inputs and compute results
    logic wrEn;      // drive the register file write port
    logic wrSelNpc;  // 0: PC to local 1, 1: nPC to local 2
    logic finish;    // completion pulse
  } trapStrobe_t;

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        trapReq,
  output logic        ready,
  output trapStrobe_t strobe
);

  trapState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    ready     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        ready = 1'b1;
        if (trapReq) begin
          strobe.capture = 1'b1;
          stateNext      = ST_SAVE_PC;
        end
      end
      ST_SAVE_PC: begin
        strobe.wrEn = 1'b1;
        stateNext   = ST_SAVE_NPC;
      end
      ST_SAVE_NPC: begin
        strobe.wrEn     = 1'b1;
        strobe.wrSelNpc = 1'b1;
        stateNext       = ST_FINISH;
      end
      ST_FINISH: begin
        strobe.finish = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R9: completion is a single-cycle pulse
  a_r9_finish_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> !strobe.finish);

  // R10: a capture is never followed directly by another capture
  a_r10_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !strobe.capture);

endmodule

// File: rtl/trap_dpath.sv
module trap_dpath
  import trap_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned NWIN     = 8,
  parameter int unsigned TT_W     = 8,
  parameter int unsigned TT_LSB   = 4,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned PC_SLOT  = 17,
  parameter int unsigned NPC_SLOT = 18,
  localparam int unsigned CW      = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  trapStrobe_t       strobe,
  input  logic [TT_W-1:0]   trapType,
  input  logic [XLEN-1:0]   curPc,
  input  logic [XLEN-1:0]   curNpc,
  input  logic [CW-1:0]     curCwp,
  input  logic              curS,
  input  logic              curEt,
  input  logic [XLEN-1:0]   curTbr,
  output logic              rfWe,
  output logic [CW-1:0]     rfWin,
  output logic [IDX_W-1:0]  rfIdx,
  output logic [XLEN-1:0]   rfData,
  output logic [CW-1:0]     newCwp,
  output logic              newS,
  output logic              newPs,
  output logic              newEt,
  output logic [XLEN-1:0]   newTbr,
  output logic [XLEN-1:0]   newPc,
  output logic [XLEN-1:0]   newNpc
);

  localparam int unsigned BASE_LSB = TT_LSB + TT_W;
  localparam logic [XLEN-1:0] INSTR_STEP = XLEN'(4);

  logic [XLEN-1:0] pcHold, npcHold, tbrHold;
  logic [CW-1:0]   cwpHold;
  logic            sHold, psHold, etHold;
  logic [XLEN-1:0] tbrCalc;

  // Vector composition: base field kept, type field inserted, low bits cleared
  generate
    if (TT_LSB > 0) begin : g_lowZero
      assign tbrCalc = {curTbr[XLEN-1:BASE_LSB], trapType, {TT_LSB{1'b0}}};
    end else begin : g_noLow
      assign tbrCalc = {curTbr[XLEN-1:BASE_LSB], trapType};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcHold  <= '0;
      npcHold <= '0;
      tbrHold <= '0;
      cwpHold <= '0;
      sHold   <= 1'b0;
      psHold  <= 1'b0;
      etHold  <= 1'b0;
    end else if (strobe.capture) begin
      pcHold  <= curPc;
      npcHold <= curNpc;
      tbrHold <= tbrCalc;
      cwpHold <= curCwp - 1'b1;   // power-of-two count wraps naturally
      psHold  <= curS;
      sHold   <= 1'b1;
      etHold  <= 1'b0;
    end
  end

  // curEt is accepted for interface completeness; entry always clears it
  logic unusedEt;
  assign unusedEt = curEt;

  assign rfWe   = strobe.wrEn;
  assign rfWin  = cwpHold;
  assign rfIdx  = strobe.wrSelNpc ? IDX_W'(NPC_SLOT) : IDX_W'(PC_SLOT);
  assign rfData = strobe.wrSelNpc ? npcHold : pcHold;

  assign newCwp = cwpHold;
  assign newS   = sHold;
  assign newPs  = psHold;
  assign newEt  = etHold;
  assign newTbr = tbrHold;
  assign newPc  = tbrHold;
  assign newNpc = tbrHold + INSTR_STEP;

  // R2: window after capture is one below the captured pointer
  a_r2_window_dec: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> ((rfWin + 1'b1) == $past(curCwp)));

  // R5: supervisor set, previous supervisor copied
  a_r5_status: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (newS && (newPs == $past(curS))));

  // R6: trap enable cleared
  a_r6_et_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !newEt);

  // R7: type field lands in the vector
  a_r7_type_field: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (newTbr[TT_LSB +: TT_W] == $past(trapType)));

endmodule

// File: rtl/trap_entry.sv
module trap_entry
  import trap_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned NWIN     = 8,
  parameter int unsigned TT_W     = 8,
  parameter int unsigned TT_LSB   = 4,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned PC_SLOT  = 17,
  parameter int unsigned NPC_SLOT = 18,
  localparam int unsigned CW      = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trapReq,
  input  logic [TT_W-1:0]  trapType,
  output logic             ready,
  input  logic [XLEN-1:0]  curPc,
  input  logic [XLEN-1:0]  curNpc,
  input  logic [CW-1:0]    curCwp,
  input  logic             curS,
  input  logic             curEt,
  input  logic [XLEN-1:0]  curTbr,
  output logic             rfWe,
  output logic [CW-1:0]    rfWin,
  output logic [IDX_W-1:0] rfIdx,
  output logic [XLEN-1:0]  rfData,
  output logic [CW-1:0]    newCwp,
  output logic             newS,
  output logic             newPs,
  output logic             newEt,
  output logic [XLEN-1:0]  newTbr,
  output logic [XLEN-1:0]  newPc,
  output logic [XLEN-1:0]  newNpc,
  output logic             done,
  output logic             excPendClr
);

  trapStrobe_t strobe;

  trap_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .trapReq (trapReq),
    .ready   (ready),
    .strobe  (strobe)
  );

  trap_dpath #(
    .XLEN     (XLEN),
    .NWIN     (NWIN),
    .TT_W     (TT_W),
    .TT_LSB   (TT_LSB),
    .IDX_W    (IDX_W),
    .PC_SLOT  (PC_SLOT),
    .NPC_SLOT (NPC_SLOT)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .trapType (trapType),
    .curPc    (curPc),
    .curNpc   (curNpc),
    .curCwp   (curCwp),
    .curS     (curS),
    .curEt    (curEt),
    .curTbr   (curTbr),
    .rfWe     (rfWe),
    .rfWin    (rfWin),
    .rfIdx    (rfIdx),
    .rfData   (rfData),
    .newCwp   (newCwp),
    .newS     (newS),
    .newPs    (newPs),
    .newEt    (newEt),
    .newTbr   (newTbr),
    .newPc    (newPc),
    .newNpc   (newNpc)
  );

  assign done       = strobe.finish;
  assign excPendClr = strobe.finish;

  // R3/R4: write to local 1 is followed by write to local 2
  a_r4_write_order: assert property (@(posedge clk) disable iff (!rstN)
    (rfWe && rfIdx == IDX_W'(PC_SLOT)) |=> (rfWe && rfIdx == IDX_W'(NPC_SLOT)));

  // R9: completion follows the second write
  a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (rfWe && rfIdx == IDX_W'(NPC_SLOT)) |=> (done && !rfWe));

  // R10: results hold while busy
  a_r10_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> ($stable(newTbr) && $stable(newCwp) && $stable(newPs)));

  // R3: acceptance is followed by the first write
  a_r3_first_write: assert property (@(posedge clk) disable iff (!rstN)
    (ready && trapReq) |=> (rfWe && !ready));

endmodule

// File: tb/sim_trap_entry.sv
module sim_trap_entry;

  localparam int XLEN = 32;
  localparam int NWIN = 8;
  localparam int CW   = 3;

  logic            clk = 1'b0;
  logic            rstN;
  logic            trapReq;
  logic [7:0]      trapType;
  logic            ready;
  logic [XLEN-1:0] curPc, curNpc, curTbr;
  logic [CW-1:0]   curCwp;
  logic            curS, curEt;
  logic            rfWe;
  logic [CW-1:0]   rfWin;
  logic [4:0]      rfIdx;
  logic [XLEN-1:0] rfData;
  logic [CW-1:0]   newCwp;
  logic            newS, newPs, newEt;
  logic [XLEN-1:0] newTbr, newPc, newNpc;
  logic            done, excPendClr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  trap_entry #(.XLEN(XLEN), .NWIN(NWIN)) u0 (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapType(trapType),
    .ready(ready), .curPc(curPc), .curNpc(curNpc), .curCwp(curCwp),
    .curS(curS), .curEt(curEt), .curTbr(curTbr), .rfWe(rfWe),
    .rfWin(rfWin), .rfIdx(rfIdx), .rfData(rfData), .newCwp(newCwp),
    .newS(newS), .newPs(newPs), .newEt(newEt), .newTbr(newTbr),
    .newPc(newPc), .newNpc(newNpc), .done(done), .excPendClr(excPendClr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doTrap(input int cwp, input bit s, input logic [7:0] tt,
                        input logic [31:0] tbr, input logic [31:0] pc,
                        input logic [31:0] npc, input bit poke);
    logic [CW-1:0] expWin;
    logic [31:0]   expTbr;
    expWin = CW'(cwp + NWIN - 1);
    expTbr = (tbr & 32'hFFFF_F000) | ({24'd0, tt} << 4);
    @(negedge clk);
    curCwp = CW'(cwp); curS = s; curEt = 1'b1; curTbr = tbr;
    curPc = pc; curNpc = npc; trapType = tt; trapReq = 1'b1;
    chk("R10 ready idle", {31'd0, ready}, 32'd1);
    @(negedge clk);  // first write cycle
    if (poke) begin
      // R11: scramble inputs; R10: request again while busy
      trapType = ~tt; curCwp = CW'(cwp + 3); curPc = ~pc; curNpc = ~npc;
      curS = ~s; curTbr = ~tbr;
    end else begin
      trapReq = 1'b0;
    end
    chk("R10 busy", {31'd0, ready}, 32'd0);
    chk("R3 we", {31'd0, rfWe}, 32'd1);
    chk("R3 idx", {27'd0, rfIdx}, 32'd17);
    chk("R3 data", rfData, pc);
    chk("R2 win", {29'd0, rfWin}, {29'd0, expWin});
    chk("R2 newCwp", {29'd0, newCwp}, {29'd0, expWin});
    @(negedge clk);  // second write cycle
    chk("R4 we", {31'd0, rfWe}, 32'd1);
    chk("R4 idx", {27'd0, rfIdx}, 32'd18);
    chk("R4 data", rfData, npc);
    chk("R9 no early done", {31'd0, done}, 32'd0);
    @(negedge clk);  // completion cycle
    chk("R9 done", {31'd0, done}, 32'd1);
    chk("R9 excPendClr", {31'd0, excPendClr}, 32'd1);
    chk("R4 write ends", {31'd0, rfWe}, 32'd0);
    chk("R10 busy at done", {31'd0, ready}, 32'd0);
    chk("R5 newS", {31'd0, newS}, 32'd1);
    chk("R5 newPs", {31'd0, newPs}, {31'd0, s});
    chk("R6 newEt", {31'd0, newEt}, 32'd0);
    chk("R7 newTbr", newTbr, expTbr);
    chk("R8 newPc", newPc, expTbr);
    chk("R8 newNpc", newNpc, expTbr + 32'd4);
    if (poke) chk("R11 window held", {29'd0, newCwp}, {29'd0, expWin});
    trapReq = 1'b0;
    @(negedge clk);  // back to idle
    chk("R9 done pulse", {31'd0, done}, 32'd0);
    chk("R10 ready again", {31'd0, ready}, 32'd1);
    chk("R10 no extra write", {31'd0, rfWe}, 32'd0);
    chk("R10 results kept", newTbr, expTbr);
  endtask

  initial begin
    logic [7:0] tts [4];
    tts[0] = 8'h00; tts[1] = 8'hFF; tts[2] = 8'h5A; tts[3] = 8'h80;
    rstN = 1'b0; trapReq = 1'b0; trapType = '0; curPc = '0; curNpc = '0;
    curTbr = '0; curCwp = '0; curS = 1'b0; curEt = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready", {31'd0, ready}, 32'd1);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 excPendClr", {31'd0, excPendClr}, 32'd0);
    chk("R1 rfWe", {31'd0, rfWe}, 32'd0);
    for (int c = 0; c < NWIN; c++) begin
      for (int s = 0; s < 2; s++) begin
        for (int t = 0; t < 4; t++) begin
          doTrap(c, s[0], tts[t],
                 32'hA5C3_0FFF ^ (32'(c) << 20),
                 32'h4000_0000 + 32'(c * 64 + s * 16 + t * 4),
                 32'h4000_0004 + 32'(c * 64 + s * 16 + t * 4),
                 ((c + s + t) % 3) == 0);
        end
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule